// File: doc/BRIEF.md
# DTMF Zero-Crossing Tone-Pair Decoder

This block turns two hard-limited square waves into a keypad digit. One wave comes from the low-group band and one from the high-group band. Both have already been split into bands and limited upstream. For each band, the block counts system clock cycles between successive rising crossings, which gives one period measurement per cycle of the tone. It compares each measured period against four period windows. The windows are computed at elaboration time from the clock frequency parameter. The low-group nominals are 697, 770, 852 and 941 Hz; the high-group nominals are 1209, 1336, 1477 and 1633 Hz.

Each band has its own tracking state machine with four states:

- `TRK_IDLE`: no recent crossing.
- `TRK_MEASURE`: one crossing seen, or the last period fitted no window.
- `TRK_CANDIDATE`: one period has fitted a window.
- `TRK_LOCKED`: two consecutive periods have fitted the same window.

Named transitions:

- start: IDLE to MEASURE, on any rising edge.
- first hit: MEASURE to CANDIDATE.
- confirm: CANDIDATE to LOCKED, when the same bin is seen again.
- retarget: to CANDIDATE, when a different bin is seen.
- miss: to MEASURE, when a period fits no window.
- timeout: to IDLE, when the period counter saturates.

A pair state machine combines the two bands. It has two states, `PAIR_QUIET` and `PAIR_HELD`, with transitions "pair seen" and "pair lost". It holds the early-detect flag and a 4-bit digit code. A column inhibit input suppresses every pair that uses the 1633 Hz tone.

Top module: `dtmf_zc_decoder`

## Requirements
- R1: A tone within ±(1.5% + 2 Hz) of its nominal frequency is accepted. Each bin window spans the periods of nominal × (1 ± TOL_PERMILLE/1000), with a default of ±2.6%, and all periods are derived from CLK_HZ.
- R2: A tone that deviates by 3.5% or more from every nominal in its group is not recognised, and the pair then produces no detection.
- R3: A band becomes valid only at the third rising edge after idle, that is, after two consecutive periods fall in the same bin. Its bin stays fixed while it is valid.
- R4: `early_det` is high in the cycle after both bands are valid (and not inhibited), and low in the cycle after either band is not valid.
- R5: While `early_det` is high, `digit_code` encodes the pair. Row order is 697/770/852/941 and column order is 1209/1336/1477/1633. The keypad in row-major order is 1 2 3 A / 4 5 6 B / 7 8 9 C / * 0 # D. Digits 1–9 give codes 1–9, 0 gives 10, * gives 11, # gives 12, A/B/C give 13/14/15, and D gives 0.
- R6: `digit_code` is 0 whenever `early_det` is low.
- R7: While `col4_inhibit` is high, pairs that use 1633 Hz never raise `early_det`. The other columns are unaffected.
- R8: A single period outside every window drops `early_det` within a few cycles of the edge that ends that period. Detection returns only after two good periods.
- R9: If no rising edge arrives within 9/8 of the longest accepted period of a band, that band is cleared and `early_det` falls.
- R10: After reset, `early_det` is 0 and `digit_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_sq | input | 1 | Hard-limited low-group signal (asynchronous) |
| hi_sq | input | 1 | Hard-limited high-group signal (asynchronous) |
| col4_inhibit | input | 1 | High suppresses recognition of 1633 Hz |
| early_det | output | 1 | Valid tone pair currently present |
| digit_code | output | 4 | Code of the present pair, 0 when none |

## Verification
A tracker left in the wrong state shows up within one period of the affected band. It either raises `early_det` one edge too early, or it keeps the flag up after a bad period, which would normally drop the flag about four cycles after the offending edge. A wrong bin register shows as a wrong `digit_code` as soon as the pair locks. A stuck or mis-sized period counter shows at the ports as a failure to fall within the timeout after the tones stop, or as tones near the window edges being accepted or rejected wrongly.

// File: rtl/dtmf_zc_pkg.sv
package dtmf_zc_pkg;

    typedef enum logic [1:0] {
        TRK_IDLE,
        TRK_MEASURE,
        TRK_CANDIDATE,
        TRK_LOCKED
    } trk_state_e;

    typedef enum logic {
        PAIR_QUIET,
        PAIR_HELD
    } pair_state_e;

    localparam int unsigned BINS_PER_GROUP = 4;

    // Nominal tone of a bin; bin 0 is the lowest frequency of its group.
    function automatic int unsigned tone_hz(input bit high_grp, input int unsigned idx);
        int unsigned hz;
        if (high_grp) begin
            case (idx)
                0:       hz = 1209;
                1:       hz = 1336;
                2:       hz = 1477;
                default: hz = 1633;
            endcase
        end else begin
            case (idx)
                0:       hz = 697;
                1:       hz = 770;
                2:       hz = 852;
                default: hz = 941;
            endcase
        end
        return hz;
    endfunction

    // Shortest accepted period in clock cycles (highest accepted frequency).
    function automatic int unsigned win_min(input int unsigned clk_hz,
                                            input int unsigned hz,
                                            input int unsigned tol_pm);
        longint unsigned num;
        longint unsigned den;
        num = longint'(clk_hz) * 1000;
        den = longint'(hz) * longint'(1000 + tol_pm);
        return int'(num / den);
    endfunction

    // Longest accepted period in clock cycles (lowest accepted frequency).
    function automatic int unsigned win_max(input int unsigned clk_hz,
                                            input int unsigned hz,
                                            input int unsigned tol_pm);
        longint unsigned num;
        longint unsigned den;
        num = longint'(clk_hz) * 1000;
        den = longint'(hz) * longint'(1000 - tol_pm);
        return int'(num / den);
    endfunction

    // Keypad code from row (low group) and column (high group) bins.
    function automatic logic [3:0] key_code(input logic [1:0] row, input logic [1:0] col);
        logic [3:0] code;
        if (col == 2'd3) begin
            code = (row == 2'd3) ? 4'd0 : 4'd13 + {2'b00, row};
        end else if (row == 2'd3) begin
            case (col)
                2'd0:    code = 4'd11;
                2'd1:    code = 4'd10;
                default: code = 4'd12;
            endcase
        end else begin
            code = ({2'b00, row} * 4'd3) + {2'b00, col} + 4'd1;
        end
        return code;
    endfunction

endpackage

// File: rtl/tone_bin_classifier.sv
module tone_bin_classifier
    import dtmf_zc_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 3579545,
    parameter int unsigned TOL_PM   = 26,
    parameter bit          HIGH_GRP = 1'b0,
    parameter int          CNT_W    = 13
) (
    input  logic [CNT_W-1:0] period,
    output logic             hit,
    output logic [1:0]       bin
);

    localparam int NBINS = int'(BINS_PER_GROUP);

    logic [NBINS-1:0] match;

    generate
        for (genvar b = 0; b < NBINS; b++) begin : g_bin
            localparam int unsigned LO_LIM = win_min(CLK_HZ, tone_hz(HIGH_GRP, b), TOL_PM);
            localparam int unsigned HI_LIM = win_max(CLK_HZ, tone_hz(HIGH_GRP, b), TOL_PM);
            localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO_LIM);
            localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI_LIM);
            assign match[b] = (period >= LO_C) && (period <= HI_C);
        end
    endgenerate

    // Windows are disjoint; a fixed priority keeps the encoder simple.
    always_comb begin
        hit = |match;
        bin = 2'd0;
        for (int b = NBINS - 1; b >= 0; b--) begin
            if (match[b]) bin = 2'(b);
        end
    end

endmodule

// File: rtl/band_period_tracker.sv
module band_period_tracker
    import dtmf_zc_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 3579545,
    parameter int unsigned TOL_PM   = 26,
    parameter bit          HIGH_GRP = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sq_in,
    output logic       valid,
    output logic [1:0] bin
);

    localparam int unsigned LONGEST = win_max(CLK_HZ, tone_hz(HIGH_GRP, 0), TOL_PM);
    localparam int unsigned TIMEOUT = LONGEST + LONGEST / 8;
    localparam int          CNT_W   = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] TIMEOUT_C = CNT_W'(TIMEOUT);
    localparam int          SYNC_D  = 3;

    logic [SYNC_D-1:0] sync_q;
    logic              rise;
    logic [CNT_W-1:0]  cnt_q;
    logic              expired;
    logic              cls_hit;
    logic [1:0]        cls_bin;
    trk_state_e        state_q, state_n;
    logic [1:0]        bin_q, bin_n;

    // Two-stage synchroniser plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_D-2:0], sq_in};
    end

    assign rise = sync_q[SYNC_D-2] & ~sync_q[SYNC_D-1];

    // Period counter: restarts at 1 on every rising edge, saturates at TIMEOUT.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (rise)              cnt_q <= CNT_W'(1);
        else if (cnt_q != TIMEOUT_C) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == TIMEOUT_C);

    tone_bin_classifier #(
        .CLK_HZ  (CLK_HZ),
        .TOL_PM  (TOL_PM),
        .HIGH_GRP(HIGH_GRP),
        .CNT_W   (CNT_W)
    ) u_cls (
        .period(cnt_q),
        .hit   (cls_hit),
        .bin   (cls_bin)
    );

    always_comb begin
        state_n = state_q;
        bin_n   = bin_q;
        unique case (state_q)
            TRK_IDLE: begin
                if (rise) state_n = TRK_MEASURE;
            end
            TRK_MEASURE: begin
                if (rise) begin
                    if (cls_hit) begin
                        state_n = TRK_CANDIDATE;
                        bin_n   = cls_bin;
                    end
                end else if (expired) begin
                    state_n = TRK_IDLE;
                end
            end
            TRK_CANDIDATE, TRK_LOCKED: begin
                if (rise) begin
                    if (!cls_hit) begin
                        state_n = TRK_MEASURE;
                    end else if (cls_bin == bin_q) begin
                        state_n = TRK_LOCKED;
                    end else begin
                        state_n = TRK_CANDIDATE;
                        bin_n   = cls_bin;
                    end
                end else if (expired) begin
                    state_n = TRK_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            bin_q   <= 2'd0;
        end else begin
            state_q <= state_n;
            bin_q   <= bin_n;
        end
    end

    always_comb begin
        valid = (state_q == TRK_LOCKED);
        bin   = bin_q;
    end

endmodule

// File: rtl/pair_code_combiner.sv
module pair_code_combiner
    import dtmf_zc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lo_valid,
    input  logic [1:0] lo_bin,
    input  logic       hi_valid,
    input  logic [1:0] hi_bin,
    input  logic       inhibit,
    output logic       early_det,
    output logic [3:0] code
);

    localparam logic [1:0] INHIB_COL = 2'd3;

    pair_state_e state_q, state_n;
    logic        pair_ok;
    logic [3:0]  code_q, code_n;

    always_comb begin
        pair_ok = lo_valid && hi_valid && !(inhibit && (hi_bin == INHIB_COL));
        state_n = state_q;
        code_n  = 4'd0;
        unique case (state_q)
            PAIR_QUIET: if (pair_ok)  state_n = PAIR_HELD;
            PAIR_HELD:  if (!pair_ok) state_n = PAIR_QUIET;
        endcase
        if (pair_ok) code_n = key_code(lo_bin, hi_bin);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PAIR_QUIET;
            code_q  <= 4'd0;
        end else begin
            state_q <= state_n;
            code_q  <= code_n;
        end
    end

    always_comb begin
        early_det = (state_q == PAIR_HELD);
        code      = code_q;
    end

endmodule

// File: rtl/dtmf_zc_decoder.sv
module dtmf_zc_decoder
    import dtmf_zc_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 3579545,
    parameter int unsigned TOL_PERMILLE = 26
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lo_sq,
    input  logic       hi_sq,
    input  logic       col4_inhibit,
    output logic       early_det,
    output logic [3:0] digit_code
);

    logic       lo_valid;
    logic [1:0] lo_bin;
    logic       hi_valid;
    logic [1:0] hi_bin;

    band_period_tracker #(
        .CLK_HZ  (CLK_HZ),
        .TOL_PM  (TOL_PERMILLE),
        .HIGH_GRP(1'b0)
    ) u_lo (
        .clk  (clk),
        .rst_n(rst_n),
        .sq_in(lo_sq),
        .valid(lo_valid),
        .bin  (lo_bin)
    );

    band_period_tracker #(
        .CLK_HZ  (CLK_HZ),
        .TOL_PM  (TOL_PERMILLE),
        .HIGH_GRP(1'b1)
    ) u_hi (
        .clk  (clk),
        .rst_n(rst_n),
        .sq_in(hi_sq),
        .valid(hi_valid),
        .bin  (hi_bin)
    );

    pair_code_combiner u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_valid (lo_valid),
        .lo_bin   (lo_bin),
        .hi_valid (hi_valid),
        .hi_bin   (hi_bin),
        .inhibit  (col4_inhibit),
        .early_det(early_det),
        .code     (digit_code)
    );

endmodule

// File: rtl/dtmf_zc_decoder_chk.sv
module dtmf_zc_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       col_inhibit,
    input logic       lo_valid,
    input logic [1:0] lo_bin,
    input logic       hi_valid,
    input logic [1:0] hi_bin,
    input logic       early_det,
    input logic [3:0] digit_code
);

    a_r6_code_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !early_det |-> (digit_code == 4'd0));

    a_r4_needs_both_bands: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_valid && hi_valid) |=> !early_det);

    a_r4_follows_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_valid && hi_valid && !(col_inhibit && hi_bin == 2'd3)) |=> early_det);

    a_r7_inhibit_masks_col4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_inhibit && hi_bin == 2'd3) |=> !early_det);

    a_r3_lo_bin_held: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_valid && $past(lo_valid)) |-> $stable(lo_bin));

    a_r3_hi_bin_held: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_valid && $past(hi_valid)) |-> $stable(hi_bin));

endmodule

bind dtmf_zc_decoder dtmf_zc_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .col_inhibit(col4_inhibit),
    .lo_valid   (lo_valid),
    .lo_bin     (lo_bin),
    .hi_valid   (hi_valid),
    .hi_bin     (hi_bin),
    .early_det  (early_det),
    .digit_code (digit_code)
);

// File: tb/dtmf_zc_decoder_tb.sv
module dtmf_zc_decoder_tb;

    localparam int unsigned CLK_HZ = 447443;
    localparam int unsigned TOL    = 26;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       lo_sq;
    logic       hi_sq;
    logic       col4_inhibit;
    logic       early_det;
    logic [3:0] digit_code;

    always #5 clk = ~clk;

    dtmf_zc_decoder #(.CLK_HZ(CLK_HZ), .TOL_PERMILLE(TOL)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lo_sq       (lo_sq),
        .hi_sq       (hi_sq),
        .col4_inhibit(col4_inhibit),
        .early_det   (early_det),
        .digit_code  (digit_code)
    );

    typedef struct {
        bit         est;
        logic [3:0] code;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;
    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;
    int   lo_per = 0;

    real   ROW_HZ [4] = '{697.0, 770.0, 852.0, 941.0};
    real   COL_HZ [4] = '{1209.0, 1336.0, 1477.0, 1633.0};
    string KEYS = "123A456B789C*0#D";

    function automatic int per_of(real hz);
        return $rtoi(real'(CLK_HZ) / hz + 0.5);
    endfunction

    function automatic logic [3:0] exp_code(int r, int c);
        byte k;
        k = KEYS[r * 4 + c];
        case (k)
            "0": return 4'd10;
            "*": return 4'd11;
            "#": return 4'd12;
            "A": return 4'd13;
            "B": return 4'd14;
            "C": return 4'd15;
            "D": return 4'd0;
            default: return 4'(k - "0");
        endcase
    endfunction

    // Background low-group generator; a new period value takes effect per cycle.
    initial begin
        lo_sq = 1'b0;
        forever begin
            automatic int p;
            p = lo_per;
            if (p == 0) begin
                lo_sq = 1'b0;
                @(negedge clk);
            end else begin
                lo_sq = 1'b1;
                repeat (p / 2) @(negedge clk);
                lo_sq = 1'b0;
                repeat (p - p / 2) @(negedge clk);
            end
        end
    end

    task automatic hi_pulses(int p, int n);
        for (int k = 0; k < n; k++) begin
            hi_sq = 1'b1;
            repeat (p / 2) @(negedge clk);
            hi_sq = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    endtask

    task automatic expect_now(bit est, logic [3:0] code, string tag);
        exp_t e;
        e.est  = est;
        e.code = code;
        e.tag  = tag;
        exp_q.push_back(e);
        -> sample_ev;
        #1;
    endtask

    task automatic run_pair(real fl, real fh, bit inh);
        int pl;
        int ph;
        pl = per_of(fl);
        ph = per_of(fh);
        col4_inhibit = inh;
        lo_per = pl;
        hi_pulses(ph, (3 * pl) / ph + 2);
    endtask

    task automatic go_quiet(string tag);
        lo_per = 0;
        hi_sq  = 1'b0;
        repeat (1500) @(negedge clk);
        expect_now(1'b0, 4'd0, tag);
        col4_inhibit = 1'b0;
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                vectors++;
                if (early_det !== e.est || digit_code !== e.code) begin
                    miscompares++;
                    $display("FAIL %s: actual est=%0b code=%0d, expected est=%0b code=%0d at %0t",
                             e.tag, early_det, digit_code, e.est, e.code, $time);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual run still busy, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Driver
    initial begin
        rst_n = 1'b0;
        hi_sq = 1'b0;
        col4_inhibit = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now(1'b0, 4'd0, "R10 reset state");

        // All sixteen pairs: detection and code (R4, R5), then timeout (R6, R9)
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                run_pair(ROW_HZ[r], COL_HZ[c], 1'b0);
                expect_now(1'b1, exp_code(r, c), "R4 R5 pair code");
                go_quiet("R6 R9 timeout clears");
            end
        end

        // Inhibit: 1633 Hz column suppressed, first column still decoded (R7)
        for (int r = 0; r < 4; r++) begin
            run_pair(ROW_HZ[r], COL_HZ[3], 1'b1);
            expect_now(1'b0, 4'd0, "R7 inhibited column");
            go_quiet("R9 quiet");
        end
        run_pair(ROW_HZ[2], COL_HZ[0], 1'b1);
        expect_now(1'b1, exp_code(2, 0), "R7 other column unaffected");
        go_quiet("R9 quiet");

        // Accept band edges: +/-(1.5% + 2 Hz) (R1)
        run_pair(ROW_HZ[0] * 1.015 + 2.0, COL_HZ[3] * 0.985 - 2.0, 1'b0);
        expect_now(1'b1, exp_code(0, 3), "R1 deviated accept");
        go_quiet("R9 quiet");
        run_pair(ROW_HZ[0] * 0.985 - 2.0, COL_HZ[3] * 1.015 + 2.0, 1'b0);
        expect_now(1'b1, exp_code(0, 3), "R1 deviated accept");
        go_quiet("R9 quiet");

        // Reject band: 3.5% off (R2)
        run_pair(ROW_HZ[0], COL_HZ[3] * 1.035, 1'b0);
        expect_now(1'b0, 4'd0, "R2 high band rejected");
        go_quiet("R9 quiet");
        run_pair(ROW_HZ[3] * 0.965, COL_HZ[0], 1'b0);
        expect_now(1'b0, 4'd0, "R2 low band rejected");
        go_quiet("R9 quiet");

        // Third rising edge confirms the band (R3)
        lo_per = per_of(ROW_HZ[1]);
        repeat (3 * per_of(ROW_HZ[1])) @(negedge clk);
        hi_pulses(per_of(COL_HZ[1]), 2);
        expect_now(1'b0, 4'd0, "R3 two edges not enough");
        hi_pulses(per_of(COL_HZ[1]), 1);
        expect_now(1'b1, exp_code(1, 1), "R3 third edge locks");
        go_quiet("R9 quiet");

        // Single bad period drops detection (R8)
        lo_per = per_of(ROW_HZ[2]);
        repeat (3 * per_of(ROW_HZ[2])) @(negedge clk);
        hi_pulses(per_of(COL_HZ[2]), 4);
        expect_now(1'b1, exp_code(2, 2), "R8 locked before glitch");
        hi_pulses(per_of(COL_HZ[2] * 1.05), 1);
        hi_pulses(per_of(COL_HZ[2]), 1);
        expect_now(1'b0, 4'd0, "R8 bad period drops");
        hi_pulses(per_of(COL_HZ[2]), 2);
        expect_now(1'b1, exp_code(2, 2), "R8 recovers");
        go_quiet("R9 quiet");

        done = 1'b1;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule